// File: doc/BRIEF.md
# Banked Word RAM

This block is a 4096-word by 8-bit random access memory. Its storage is split into four banks of 1024 words. The two most significant address bits feed a 2-to-4 decoder, and the decoder raises the chip select of exactly one bank. The remaining ten address bits pick the word inside that bank. Each bank is therefore reached through its own consecutive quarter of the address space.

A single direction line chooses the operation, and a memory enable qualifies every cycle. With the enable high, a low direction line stores the input byte on the rising clock edge, and a high direction line starts a read. The read result is registered and shows on the output one clock after the request. In every other cycle the output keeps the byte it last showed.

Top module: `banked_ram`

## Requirements
- R1: Every one of the 4096 word addresses stores its own byte independently, so that a byte written to an address is returned by a later read of that address.
- R2: Exactly one bank chip select is high in every cycle. The high select is the one numbered by address bits [11:10], so bank k covers addresses k*1024 to k*1024+1023.
- R3: Address bits [9:0] pick the word inside the selected bank. Words that share the same low ten bits but lie in different banks never alias.
- R4: While the memory enable is 0, no word changes and the data output holds, whatever the direction line and data input carry.
- R5: With the enable at 1 and the direction line at 0 (write), the input byte is stored on the rising clock edge, and the data output does not change in the following cycle.
- R6: With the enable at 1 and the direction line at 1 (read), the addressed byte appears on the data output after the next rising clock edge, which gives one cycle of latency.
- R7: After a read, the data output keeps that byte through any following cycles that contain no read.
- R8: A synchronous active-high reset drives the data output to 0.
- R9: A read issued in the cycle right after a write to the same address returns the newly written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | input | 1 | Memory enable; 0 means no operation |
| rd_nwr | input | 1 | Direction: 1 = read, 0 = write |
| addr | input | 12 | Word address; bits [11:10] select the bank |
| din | input | 8 | Byte to store on a write |
| dout | output | 8 | Registered read data |

## Verification
The bench writes a different byte to the first and last word of every bank, and to a shared low offset in all four banks, and then reads them all back. A decoder that ignored or swapped an upper address bit would show up as one bank's byte in another bank's words. A write attempted with the enable low is followed by a read of that word, which catches a bank that writes without checking the enable. A read issued right after a write to the same address catches a read path that is a cycle stale. The bench also checks the output in every idle, disabled and write cycle, so an output that fails to hold or that takes the wrong latency is reported.

// File: rtl/bram_pkg.sv
package bram_pkg;

    localparam int ADDR_W_DEF  = 12;
    localparam int DATA_W_DEF  = 8;
    localparam int BANK_AW_DEF = 10;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;

    typedef struct packed {
        logic wr;
        logic rd;
    } bank_cmd_t;

    function automatic bank_cmd_t make_cmd(input logic en, input dir_e dir);
        bank_cmd_t c;
        c.wr = en && (dir == DIR_WRITE);
        c.rd = en && (dir == DIR_READ);
        return c;
    endfunction

endpackage

// File: rtl/bank_decoder.sv
module bank_decoder #(
    parameter int SEL_W = 2,
    parameter int NBANK = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [NBANK-1:0] cs
);
    always_comb begin
        cs      = '0;
        cs[sel] = 1'b1;
    end
endmodule

// File: rtl/ram_bank.sv
module ram_bank
    import bram_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs,
    input  bank_cmd_t     cmd,
    input  logic [AW-1:0] offs,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (cs && cmd.wr) begin
            mem[offs] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (cs && cmd.rd) begin
            rdata <= mem[offs];
        end
    end
endmodule

// File: rtl/read_select.sv
module read_select #(
    parameter int SEL_W = 2,
    parameter int DW    = 8,
    localparam int NBANK = 1 << SEL_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd_strobe,
    input  logic [SEL_W-1:0]          sel,
    input  logic [NBANK-1:0][DW-1:0]  bank_rdata,
    output logic [DW-1:0]             dout
);
    logic [SEL_W-1:0] last_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_sel <= '0;
        end else if (rd_strobe) begin
            last_sel <= sel;
        end
    end

    assign dout = bank_rdata[last_sel];
endmodule

// File: rtl/banked_ram.sv
module banked_ram
    import bram_pkg::*;
#(
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int DATA_W  = DATA_W_DEF,
    parameter int BANK_AW = BANK_AW_DEF,
    localparam int SEL_W  = ADDR_W - BANK_AW,
    localparam int NBANK  = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_en,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [SEL_W-1:0]               bank_sel;
    logic [BANK_AW-1:0]             bank_offs;
    logic [NBANK-1:0]               bank_cs;
    logic [NBANK-1:0][DATA_W-1:0]   bank_rdata;
    bank_cmd_t                      cmd;

    assign bank_sel  = addr[ADDR_W-1:BANK_AW];
    assign bank_offs = addr[BANK_AW-1:0];
    assign cmd       = make_cmd(mem_en, dir_e'(rd_nwr));

    bank_decoder #(.SEL_W(SEL_W), .NBANK(NBANK)) u_dec (
        .sel (bank_sel),
        .cs  (bank_cs)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        ram_bank #(.AW(BANK_AW), .DW(DATA_W)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .cs    (bank_cs[b]),
            .cmd   (cmd),
            .offs  (bank_offs),
            .wdata (din),
            .rdata (bank_rdata[b])
        );
    end

    read_select #(.SEL_W(SEL_W), .DW(DATA_W)) u_rsel (
        .clk        (clk),
        .rst        (rst),
        .rd_strobe  (cmd.rd),
        .sel        (bank_sel),
        .bank_rdata (bank_rdata),
        .dout       (dout)
    );
endmodule

// File: rtl/banked_ram_chk.sv
module banked_ram_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2,
    parameter int NBANK  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_en,
    input logic              rd_nwr,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dout,
    input logic [NBANK-1:0]  bank_cs
);
    // R2
    cs_single_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(bank_cs) == 1);

    // R2
    cs_match_chk: assert property (@(posedge clk) disable iff (rst)
        bank_cs[addr[ADDR_W-1 -: SEL_W]] == 1'b1);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_en |=> $stable(dout));

    // R5
    write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !rd_nwr) |=> $stable(dout));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (dout == '0));
endmodule

bind banked_ram banked_ram_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W),
    .NBANK  (NBANK)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mem_en  (mem_en),
    .rd_nwr  (rd_nwr),
    .addr    (addr),
    .dout    (dout),
    .bank_cs (bank_cs)
);

// File: tb/banked_ram_test.sv
`timescale 1ns/1ps
module banked_ram_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_en = 1'b0;
    logic        rd_nwr = 1'b1;
    logic [11:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [7:0] data;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    logic [7:0] model [int];
    logic [7:0] last_exp = 8'h00;

    always #4 clk = ~clk;

    banked_ram uut (
        .clk    (clk),
        .rst    (rst),
        .mem_en (mem_en),
        .rd_nwr (rd_nwr),
        .addr   (addr),
        .din    (din),
        .dout   (dout)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dout=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: one operation per cycle, inputs change on the falling edge.
    task automatic op(input logic en, input logic rw, input int a,
                      input logic [7:0] d, input string tag);
        @(negedge clk);
        mem_en = en;
        rd_nwr = rw;
        addr   = 12'(a);
        din    = d;
        if (en && !rw) model[a] = d;
        if (en && rw) begin
            exp_t e;
            e.data = model[a];
            e.tag  = tag;
            sb_q.push_back(e);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        op(1'b1, 1'b0, a, d, "R5");
    endtask

    task automatic rd(input int a, input string tag);
        op(1'b1, 1'b1, a, 8'h00, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(1'b0, 1'b1, 0, 8'h00, "R4");
    endtask

    // Monitor: compare 1 ns after each rising edge.
    always @(posedge clk) begin
        logic  s_rst, s_en, s_rw;
        string htag;
        s_rst = rst;
        s_en  = mem_en;
        s_rw  = rd_nwr;
        #1;
        if (s_rst) begin
            last_exp = 8'h00;
        end else if (s_en && s_rw) begin
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL R6: read with empty scoreboard at %0t", $time);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(dout, e.data, e.tag);
                last_exp = e.data;
            end
        end else begin
            htag = !s_en ? "R4" : "R5";
            check(dout, last_exp, htag);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(dout, 8'h00, "R8");

        // R2 R3: boundary words of every bank and a shared low offset
        for (int b = 0; b < 4; b++) begin
            wr(b*1024,        8'h10 + 8'(b));
            wr(b*1024 + 1023, 8'hE0 + 8'(b));
            wr(b*1024 + 5,    8'h50 + 8'(b*3));
        end
        for (int b = 0; b < 4; b++) begin
            rd(b*1024,        "R2");
            rd(b*1024 + 1023, "R2");
            rd(b*1024 + 5,    "R3");
        end

        // R4: disabled write must not change the word, output holds
        op(1'b0, 1'b0, 0, 8'hFF, "R4");
        op(1'b0, 1'b1, 2048, 8'hAA, "R4");
        rd(0, "R4");

        // R9: write then immediate read of the same address
        wr(3000, 8'h3C);
        rd(3000, "R9");
        wr(1024, 8'hC3);
        rd(1024, "R9");

        // R6 R7: read then several idle and write cycles hold the value
        rd(2048 + 1023, "R6");
        idle(3);
        wr(7, 8'h77);
        op(1'b1, 1'b0, 4095, 8'h9A, "R7");
        rd(4095, "R7");

        // R1: spread pattern across the whole array
        for (int i = 0; i < 64; i++) wr(i*64 + (i % 7), 8'(i*37 + 11));
        for (int i = 0; i < 64; i++) rd(i*64 + (i % 7), "R1");

        idle(2);
        @(negedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R6: %0d reads produced no result", sb_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule